// File: doc/BRIEF.md
# Burst Address Sequencer

This block supplies the address for a short memory burst of up to four beats. A start strobe captures a full external address. The next three addresses are produced inside the block. Only the two lowest address bits change. The upper bits stay at the captured value for the whole burst. A burst can be opened by either of two start strobes: a processor-side strobe and a controller-side strobe. Both capture the same address input. A separate step input moves the burst on by one beat.

Two beat orderings are supported, chosen by an order-select input that is captured together with the address. In linear order the low bits count upward from the captured offset and wrap within the aligned group of four. In interleaved order the low bits are the captured offset XORed with a beat counter running 0, 1, 2, 3. When neither a strobe nor a step is present, the address is held, which inserts a wait beat. Stepping past the fourth beat returns to the first address of the same group.

A small controller has two states. IDLE means nothing has been captured since reset. BURST means a base address is held. Its transitions are:
- OPEN: IDLE to BURST, on a strobe.
- RELOAD: BURST to BURST, on a strobe, which clears the beat counter.
- STEP: BURST to BURST, on the step input, which increments the beat counter.
- WAIT: any state to itself, with no strobe and no step.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, `addr_out` is all zeros and `burst_pos` is 0.
- R2: A cycle with `proc_strobe` or `ctrl_strobe` high captures `addr_in` and `ilv_mode`. From the next cycle, `addr_out` equals the captured address and `burst_pos` is 0.
- R3: A strobe wins over `advance` in the same cycle, and `proc_strobe` together with `ctrl_strobe` is a single capture. In both cases the result is the R2 capture and no step.
- R4: With a burst open and no strobe, `advance` high increments `burst_pos` by one, modulo 4, from the next cycle.
- R5: With `ilv_mode` low at capture (linear), `addr_out[1:0]` equals (captured low bits + `burst_pos`) mod 4.
- R6: With `ilv_mode` high at capture (interleaved), `addr_out[1:0]` equals the captured low bits XOR `burst_pos`.
- R7: `addr_out[ADDR_W-1:2]` keeps the captured value for the whole burst, whatever `addr_in` does between strobes.
- R8: A cycle with no strobe and no `advance` leaves `addr_out` and `burst_pos` unchanged.
- R9: An `advance` after the fourth beat returns `addr_out` to the first address of the burst, with `burst_pos` 0.
- R10: Before the first strobe after reset, `advance` has no effect and `addr_out` stays all zeros.
- R11: Changing `ilv_mode` in the middle of a burst does not change the ordering. Only the value captured at the strobe counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| proc_strobe | input | 1 | Processor-side burst start, highest priority |
| ctrl_strobe | input | 1 | Controller-side burst start |
| advance | input | 1 | Step the burst by one beat |
| ilv_mode | input | 1 | Ordering select, captured at a strobe: 0 linear, 1 interleaved |
| addr_in | input | ADDR_W | External start address |
| addr_out | output | ADDR_W | Current burst address |
| burst_pos | output | 2 | Beat index within the burst, 0 to 3 |

## Verification
The inline assertions check the following on every cycle:
- a strobe clears the beat index and captures the upper address bits;
- a step increments the index modulo four;
- an idle cycle leaves the address and index still;
- the base and mode registers do not move between strobes.

Other behaviours can only be shown by the bench's scenarios. These are:
- the exact beat order for each of the four start offsets in both orderings;
- the wrap back to the first beat;
- that a mode change in mid-burst has no effect;
- that steps before any capture are ignored.

The bench compares these against an ordering table it holds independently.

// File: rtl/burst_pkg.sv
package burst_pkg;
    localparam int CNT_W     = 2;
    localparam int BURST_LEN = 1 << CNT_W;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } burst_state_t;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_t;
endpackage

// File: rtl/burst_seq_fsm.sv
module burst_seq_fsm
    import burst_pkg::*;
#(
    parameter int SEQ_W = CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             proc_strobe,
    input  logic             ctrl_strobe,
    input  logic             advance,
    output logic             load_en,
    output logic             active,
    output logic [SEQ_W-1:0] seq_cnt
);
    burst_state_t state_q, state_d;
    logic         step_en;

    // Processor strobe first, controller strobe second: both capture the same address.
    assign load_en = proc_strobe | ctrl_strobe;
    assign step_en = !load_en && advance && (state_q == ST_BURST);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (load_en) state_d = ST_BURST;   // OPEN
            ST_BURST: state_d = ST_BURST;                // RELOAD / STEP / WAIT
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       seq_cnt <= '0;
        else if (load_en) seq_cnt <= '0;
        else if (step_en) seq_cnt <= seq_cnt + 1'b1;
    end

    assign active = (state_q == ST_BURST);

    assert_load_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_strobe || ctrl_strobe) |=> (seq_cnt == '0) && active);

    assert_strobe_beats_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_strobe && advance) |=> (seq_cnt == '0));

    assert_step_increments_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !proc_strobe && !ctrl_strobe && advance)
        |=> (seq_cnt == SEQ_W'($past(seq_cnt) + 1'b1)));

    assert_wait_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_strobe && !ctrl_strobe && !advance) |=> $stable(seq_cnt));

    assert_idle_ignores_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !proc_strobe && !ctrl_strobe) |=> (!active && seq_cnt == '0));
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg
    import burst_pkg::*;
#(
    parameter int ADDR_W = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              ilv_mode,
    output logic [ADDR_W-1:0] base_q,
    output order_t            mode_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            mode_q <= ORD_LINEAR;
        end else if (load_en) begin
            base_q <= addr_in;
            mode_q <= ilv_mode ? ORD_INTERLEAVE : ORD_LINEAR;
        end
    end

    assert_base_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(base_q));

    assert_mode_fixed_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(mode_q));
endmodule

// File: rtl/burst_order.sv
module burst_order
    import burst_pkg::*;
#(
    parameter int SEQ_W = CNT_W
) (
    input  order_t           mode,
    input  logic [SEQ_W-1:0] base_lo,
    input  logic [SEQ_W-1:0] seq_cnt,
    output logic [SEQ_W-1:0] addr_lo
);
    logic [SEQ_W-1:0] lin_lo;
    logic [SEQ_W-1:0] ilv_lo;

    // Linear: truncating add wraps inside the aligned group.
    assign lin_lo = base_lo + seq_cnt;
    assign ilv_lo = base_lo ^ seq_cnt;

    always_comb begin
        unique case (mode)
            ORD_LINEAR:     addr_lo = lin_lo;
            ORD_INTERLEAVE: addr_lo = ilv_lo;
            default:        addr_lo = lin_lo;
        endcase
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              proc_strobe,
    input  logic              ctrl_strobe,
    input  logic              advance,
    input  logic              ilv_mode,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic [1:0]        burst_pos
);
    localparam int HI_W = ADDR_W - CNT_W;

    logic              load_en;
    logic              active;
    logic [CNT_W-1:0]  seq_cnt;
    logic [ADDR_W-1:0] base_q;
    order_t            mode_q;
    logic [CNT_W-1:0]  addr_lo;

    burst_seq_fsm #(.SEQ_W(CNT_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .proc_strobe (proc_strobe),
        .ctrl_strobe (ctrl_strobe),
        .advance     (advance),
        .load_en     (load_en),
        .active      (active),
        .seq_cnt     (seq_cnt)
    );

    burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .addr_in  (addr_in),
        .ilv_mode (ilv_mode),
        .base_q   (base_q),
        .mode_q   (mode_q)
    );

    burst_order #(.SEQ_W(CNT_W)) u_order (
        .mode    (mode_q),
        .base_lo (base_q[CNT_W-1:0]),
        .seq_cnt (seq_cnt),
        .addr_lo (addr_lo)
    );

    assign addr_out  = {base_q[ADDR_W-1:CNT_W], addr_lo};
    assign burst_pos = seq_cnt;

    assert_capture_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_strobe || ctrl_strobe)
        |=> (addr_out[ADDR_W-1:CNT_W] == $past(addr_in[ADDR_W-1:CNT_W])));

    assert_upper_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_strobe && !ctrl_strobe) |=> $stable(addr_out[ADDR_W-1:CNT_W]));

    assert_wait_address_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_strobe && !ctrl_strobe && !advance) |=> $stable(addr_out));

    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !proc_strobe && !ctrl_strobe) |=> (addr_out == '0));

    initial begin
        assert_width_ok: assert (HI_W > 0);
    end
endmodule

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;
    localparam int AW = 21;

    // {mode, start offset[1:0], beat0..beat3 low bits (2 bits each, beat0 in MSBs)}
    localparam logic [10:0] ORDER_TAB [8] = '{
        {1'b0, 2'd0, 8'h1B}, {1'b0, 2'd1, 8'h6C},
        {1'b0, 2'd2, 8'hB1}, {1'b0, 2'd3, 8'hC6},
        {1'b1, 2'd0, 8'h1B}, {1'b1, 2'd1, 8'h4E},
        {1'b1, 2'd2, 8'hB1}, {1'b1, 2'd3, 8'hE4}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          proc_strobe, ctrl_strobe, advance, ilv_mode;
    logic [AW-1:0] addr_in;
    logic [AW-1:0] addr_out;
    logic [1:0]    burst_pos;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) i_burst_addr_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .proc_strobe (proc_strobe),
        .ctrl_strobe (ctrl_strobe),
        .advance     (advance),
        .ilv_mode    (ilv_mode),
        .addr_in     (addr_in),
        .addr_out    (addr_out),
        .burst_pos   (burst_pos)
    );

    task automatic drive(input logic p, input logic c, input logic a,
                         input logic m, input logic [AW-1:0] ad);
        @(negedge clk);
        proc_strobe = p; ctrl_strobe = c; advance = a; ilv_mode = m; addr_in = ad;
        @(posedge clk);
        #1;
    endtask

    task automatic chk_addr(input string req, input logic [AW-1:0] exp);
        checks++;
        if (addr_out !== exp) begin
            errors++;
            $display("FAIL %s addr_out actual=%h expected=%h", req, addr_out, exp);
        end
    endtask

    task automatic chk_pos(input string req, input logic [1:0] exp);
        checks++;
        if (burst_pos !== exp) begin
            errors++;
            $display("FAIL %s burst_pos actual=%0d expected=%0d", req, burst_pos, exp);
        end
    endtask

    function automatic logic [1:0] slot(input logic [7:0] seq, input int k);
        return seq[(3 - k) * 2 +: 2];
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] base;
        logic [AW-3:0] up;
        rst_n = 1'b0; proc_strobe = 0; ctrl_strobe = 0; advance = 0; ilv_mode = 0;
        addr_in = '0;
        repeat (3) @(posedge clk);
        #1;
        chk_addr("R1", '0);
        chk_pos("R1", 2'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R10: steps before any capture are ignored
        drive(0, 0, 1, 0, 21'h1ABCD);
        drive(0, 0, 1, 1, 21'h0F0F3);
        chk_addr("R10", '0);
        chk_pos("R10", 2'd0);

        // Table walk: every start offset in both orders
        for (int i = 0; i < 8; i++) begin
            logic       m;
            logic [1:0] st;
            logic [7:0] seq;
            string      ord;
            m   = ORDER_TAB[i][10];
            st  = ORDER_TAB[i][9:8];
            seq = ORDER_TAB[i][7:0];
            ord = m ? "R6" : "R5";
            up  = (AW-2)'(i * 40503 + 977);
            base = {up, st};
            drive(i % 2 == 0, i % 2 == 1, 0, m, base);      // R2 capture
            chk_addr("R2", {up, slot(seq, 0)});
            chk_pos("R2", 2'd0);
            for (int k = 1; k < 4; k++) begin
                if (k == 2) begin
                    drive(0, 0, 0, m, ~base);                 // R8 wait beat
                    chk_addr("R8", {up, slot(seq, 1)});
                    chk_pos("R8", 2'd1);
                end
                drive(0, 0, 1, m, ~base);                     // R7 addr_in ignored
                chk_addr(ord, {up, slot(seq, k)});
                chk_pos("R4", 2'(k));
            end
            drive(0, 0, 1, m, ~base);
            chk_addr("R9", {up, slot(seq, 0)});
            chk_pos("R9", 2'd0);
            checks++;
            if (addr_out[AW-1:2] !== up) begin
                errors++;
                $display("FAIL R7 upper actual=%h expected=%h", addr_out[AW-1:2], up);
            end
        end

        // R3: both strobes plus advance in one cycle capture, no step
        drive(1, 1, 1, 0, 21'h12345);
        chk_addr("R3", 21'h12345);
        chk_pos("R3", 2'd0);
        drive(0, 0, 1, 0, 21'h0);
        chk_pos("R4", 2'd1);
        drive(1, 0, 1, 1, 21'h0AAAA);
        chk_addr("R3", 21'h0AAAA);
        chk_pos("R3", 2'd0);
        drive(0, 1, 1, 0, 21'h15557);
        chk_addr("R3", 21'h15557);
        chk_pos("R3", 2'd0);

        // R11: linear start 1, flip order select mid-burst
        drive(1, 0, 0, 0, 21'h00101);
        drive(0, 0, 1, 1, 21'h0);
        chk_addr("R11", 21'h00102);
        drive(0, 0, 1, 1, 21'h0);
        chk_addr("R11", 21'h00103);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule